// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer with a small register interface on a single clock. Configuration and control use magic values written to a command-key location. Start and refresh are key writes, not control bits. One key value opens the prescaler, reload and window registers for writing, and any other key value closes them again. Once started, the watchdog runs a prescaled down-counter from the reload value. When the counter runs out, the block raises a one-cycle reset request and starts a new period.

The block counts only on cycles where the tick-enable input is high. This lets a slow timebase be modelled without a second clock domain. Prescaler and reload writes take effect in a shadow register first. A busy flag stays set until the new value has been carried over, and the old value stays in force until then. A window value catches a refresh that comes too early, while the counter is still above the window, and treats it as a fault.

Top module: `kwdt_top`

## Requirements
- R1: After reset, reads return prescaler code 0 at address 0x04, reload 0xFFF at 0x08, window 0xFFF at 0x10, status 0 at 0x0C, and 0 at the key address 0x00. The reset request output is low.
- R2: A key write (address 0x00, key in bits 15:0) of 0x5555 permits writes to addresses 0x04, 0x08 and 0x10. Any other key value withdraws that permission. A register write made without permission leaves its readback value and the status unchanged.
- R3: The prescaler code sits in bits 2:0 of address 0x04. Codes 0 to 6 divide the tick rate by 4, 8, 16, 32, 64, 128 and 256. Code 7 divides by 256.
- R4: Key 0xCCCC starts the watchdog. The reset request then goes high for exactly one cycle after T = (reload+1) × divide tick-enabled cycles. The counter then reloads, and the request repeats every T ticks.
- R5: The prescaler, the counter and the busy-flag timers advance only on cycles where tick_en is high.
- R6: Status bit 0 is the prescaler busy flag and status bit 1 is the reload busy flag. Each flag is set by an accepted write to its register. It clears on the 4th tick-enabled cycle after that write. Until it clears, the previous value governs the counter.
- R7: Key 0xAAAA reloads the counter and clears the prescaler while the watchdog runs. A refresh before the start has no effect.
- R8: A refresh while the counter is strictly above the window value raises the one-cycle reset request. A refresh at or below the window value does not. Window writes take effect at once.
- R9: No key write stops a running watchdog. Only the reset input returns it to the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase enable; counting happens only when high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (5) | Register byte address |
| wr_data | input | DATA_W (16) | Write data |
| rd_data | output | DATA_W (16) | Combinational read data for addr |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench measures the period exactly, in ticks, from the start or refresh edge to the request. It runs random reload values, prescaler codes and tick-enable gaps, so an off-by-one in the prescaler or counter shows up as a period that is one divide ratio or one tick off. It writes a new reload while the busy flag is still set and then refreshes. A design that let the pending value act early would produce the new period too soon. The window test hits both sides of the boundary: counter equal to the window, and counter one above it. A design using the wrong comparison would flag the wrong side. It also writes registers while locked, after a lock key, and after an unrelated key. A design with a sticky unlock would accept those writes.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
   localparam int unsigned OFF_KEY  = 'h00;
   localparam int unsigned OFF_PRE  = 'h04;
   localparam int unsigned OFF_RLD  = 'h08;
   localparam int unsigned OFF_STAT = 'h0C;
   localparam int unsigned OFF_WIN  = 'h10;

   localparam int unsigned KEY_W = 16;
   localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
   localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
   localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;

   // Highest prescaler code with its own ratio; larger codes saturate.
   localparam int unsigned DIV_CODE_MAX = 6;
   // Smallest divide ratio, as a power of two.
   localparam int unsigned DIV_BASE_LOG = 2;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_START = 2'd1,
      CMD_FEED  = 2'd2
   } kwdt_cmd_e;
endpackage

// File: rtl/kwdt_keydec.sv
`timescale 1ns/1ps
module kwdt_keydec
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              unlocked,
   output kwdt_cmd_e         cmd
);
   logic              key_wr;
   logic [KEY_W-1:0]  key_val;

   assign key_wr  = wr_en && (addr == ADDR_W'(OFF_KEY));
   assign key_val = wr_data[KEY_W-1:0];

   always_comb begin
      cmd = CMD_NONE;
      if (key_wr) begin
         if (key_val == KEY_START)
            cmd = CMD_START;
         else if (key_val == KEY_FEED)
            cmd = CMD_FEED;
      end
   end

   // Unlock is granted by one key value and dropped by every other one.
   always_ff @(posedge clk) begin
      if (!rst_n)
         unlocked <= 1'b0;
      else if (key_wr)
         unlocked <= (key_val == KEY_OPEN);
   end
endmodule

// File: rtl/kwdt_shadow.sv
`timescale 1ns/1ps
module kwdt_shadow #(
   parameter int unsigned      W          = 12,
   parameter logic [W-1:0]     RST_VAL    = '1,
   parameter int unsigned      SYNC_TICKS = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] pending,
   output logic [W-1:0] active,
   output logic         busy
);
   localparam int unsigned CW = $clog2(SYNC_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

   logic [CW-1:0] sync_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending  <= RST_VAL;
         active   <= RST_VAL;
         busy     <= 1'b0;
         sync_cnt <= '0;
      end else if (load) begin
         pending  <= din;
         busy     <= 1'b1;
         sync_cnt <= '0;
      end else if (busy && tick_en) begin
         if (sync_cnt == LAST) begin
            busy   <= 1'b0;
            active <= pending;
         end else begin
            sync_cnt <= sync_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/kwdt_core.sv
`timescale 1ns/1ps
module kwdt_core
   import kwdt_pkg::*;
#(
   parameter int unsigned RLD_W = 12,
   parameter int unsigned PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  kwdt_cmd_e        cmd,
   input  logic [PRE_W-1:0] pre_code,
   input  logic [RLD_W-1:0] reload,
   input  logic [RLD_W-1:0] window,
   output logic             running,
   output logic             rst_req
);
   localparam int unsigned PCW = DIV_CODE_MAX + DIV_BASE_LOG;
   localparam logic [PRE_W-1:0] CODE_TOP = PRE_W'(DIV_CODE_MAX);

   logic [PRE_W-1:0] code_eff;
   logic [PCW:0]     div_full;
   logic [PCW-1:0]   div_last;
   logic [PCW-1:0]   pre_cnt;
   logic [RLD_W-1:0] count;
   logic             pre_wrap;

   assign code_eff = (pre_code > CODE_TOP) ? CODE_TOP : pre_code;
   assign div_full = (PCW+1)'(1 << DIV_BASE_LOG) << code_eff;
   assign div_last = PCW'(div_full - 1'b1);
   assign pre_wrap = (pre_cnt >= div_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         count   <= '0;
         pre_cnt <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (cmd == CMD_START && !running) begin
            running <= 1'b1;
            count   <= reload;
            pre_cnt <= '0;
         end else if (cmd == CMD_FEED && running) begin
            count   <= reload;
            pre_cnt <= '0;
            if (count > window)
               rst_req <= 1'b1;
         end else if (running && tick_en) begin
            if (pre_wrap) begin
               pre_cnt <= '0;
               if (count == '0) begin
                  rst_req <= 1'b1;
                  count   <= reload;
               end else begin
                  count <= count - 1'b1;
               end
            end else begin
               pre_cnt <= pre_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned RLD_W      = 12,
   parameter int unsigned PRE_W      = 3,
   parameter int unsigned SYNC_TICKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req
);
   generate
      if (DATA_W < KEY_W || DATA_W < RLD_W) begin : g_bad_data_w
         $error("kwdt_top: DATA_W too narrow for key or reload");
      end
      if (PRE_W < 3) begin : g_bad_pre_w
         $error("kwdt_top: PRE_W must hold every divide code");
      end
      if (SYNC_TICKS < 1) begin : g_bad_sync
         $error("kwdt_top: SYNC_TICKS must be at least 1");
      end
      if ((1 << ADDR_W) <= OFF_WIN) begin : g_bad_addr_w
         $error("kwdt_top: ADDR_W cannot reach every register");
      end
   endgenerate

   logic             unlocked;
   kwdt_cmd_e        cmd;
   logic             running;
   logic             pre_load, rld_load, win_load;
   logic [PRE_W-1:0] pre_pending, pre_active;
   logic [RLD_W-1:0] rld_pending, rld_active;
   logic             busy_pre, busy_rld;
   logic [RLD_W-1:0] window;

   kwdt_keydec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_keydec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .unlocked (unlocked),
      .cmd      (cmd)
   );

   assign pre_load = wr_en && unlocked && (addr == ADDR_W'(OFF_PRE));
   assign rld_load = wr_en && unlocked && (addr == ADDR_W'(OFF_RLD));
   assign win_load = wr_en && unlocked && (addr == ADDR_W'(OFF_WIN));

   kwdt_shadow #(.W(PRE_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_pre_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .load    (pre_load),
      .din     (wr_data[PRE_W-1:0]),
      .pending (pre_pending),
      .active  (pre_active),
      .busy    (busy_pre)
   );

   kwdt_shadow #(.W(RLD_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rld_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .load    (rld_load),
      .din     (wr_data[RLD_W-1:0]),
      .pending (rld_pending),
      .active  (rld_active),
      .busy    (busy_rld)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         window <= '1;
      else if (win_load)
         window <= wr_data[RLD_W-1:0];
   end

   kwdt_core #(.RLD_W(RLD_W), .PRE_W(PRE_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .cmd      (cmd),
      .pre_code (pre_active),
      .reload   (rld_active),
      .window   (window),
      .running  (running),
      .rst_req  (rst_req)
   );

   always_comb begin
      rd_data = '0;
      if (addr == ADDR_W'(OFF_PRE))
         rd_data = DATA_W'(pre_pending);
      else if (addr == ADDR_W'(OFF_RLD))
         rd_data = DATA_W'(rld_pending);
      else if (addr == ADDR_W'(OFF_STAT))
         rd_data = DATA_W'({busy_rld, busy_pre});
      else if (addr == ADDR_W'(OFF_WIN))
         rd_data = DATA_W'(window);
   end
endmodule

// File: rtl/kwdt_chk.sv
`timescale 1ns/1ps
module kwdt_chk
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic              unlocked,
   input logic              running,
   input logic              busy_pre,
   input logic              busy_rld,
   input logic              rst_req
);
   // R9
   run_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(running));

   // R4
   req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(running));

   // R6
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_pre) |-> $past(wr_en && unlocked && addr == ADDR_W'(OFF_PRE)));

   // R5
   busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_rld) |-> $past(tick_en));

   // R2
   locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !unlocked && !busy_rld && addr == ADDR_W'(OFF_RLD)) |=> !busy_rld);
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .wr_en    (wr_en),
   .addr     (addr),
   .unlocked (unlocked),
   .running  (running),
   .busy_pre (busy_pre),
   .busy_rld (busy_rld),
   .rst_req  (rst_req)
);

// File: tb/kwdt_top_test.sv
`timescale 1ns/1ps
module kwdt_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        rst_req;
   int          checks = 0;
   int          fails = 0;

   kwdt_top uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
   );

   always #2 clk = ~clk;

   function automatic int exp_period(int rld, int code);
      int c;
      c = (code > 6) ? 6 : code;
      return (rld + 1) * (4 << c);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; tick_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      addr = a;
      #0.5;
      d = rd_data;
   endtask

   // Counts edges (or tick-enabled edges when rnd is set) until rst_req is seen.
   task automatic measure(input bit rnd, input int limit, output int n);
      bit te;
      n = 0;
      do begin
         te = rnd ? 1'($urandom % 2) : 1'b1;
         tick_en = te;
         @(negedge clk);
         if (te) n++;
      end while (!rst_req && n < limit);
   endtask

   task automatic setup(input int rld, input int code);
      wr(5'h00, 16'h5555);
      wr(5'h04, 16'(code));
      wr(5'h08, 16'(rld));
      tick_en = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      #600000;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int n;
      int seen;
      void'($urandom(32'd20240));

      // R1 reset state
      do_reset();
      rd(5'h04, d); check(d == 16'h0,   "R1 pre",    d, 0);
      rd(5'h08, d); check(d == 16'hFFF, "R1 reload", d, 'hFFF);
      rd(5'h10, d); check(d == 16'hFFF, "R1 window", d, 'hFFF);
      rd(5'h0C, d); check(d == 16'h0,   "R1 status", d, 0);
      rd(5'h00, d); check(d == 16'h0,   "R1 key",    d, 0);
      check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);

      // R2 write protection
      wr(5'h08, 16'h123);
      rd(5'h08, d); check(d == 16'hFFF, "R2 locked write", d, 'hFFF);
      rd(5'h0C, d); check(d == 16'h0,   "R2 locked status", d, 0);
      wr(5'h00, 16'h5555); wr(5'h00, 16'h0000); wr(5'h08, 16'h055);
      rd(5'h08, d); check(d == 16'hFFF, "R2 after lock key", d, 'hFFF);
      wr(5'h00, 16'h5555); wr(5'h00, 16'h1234); wr(5'h10, 16'h010);
      rd(5'h10, d); check(d == 16'hFFF, "R2 after other key", d, 'hFFF);
      wr(5'h00, 16'h5555); wr(5'h10, 16'h010);
      rd(5'h10, d); check(d == 16'h010, "R2 unlocked window", d, 'h10);
      wr(5'h08, 16'h020);
      rd(5'h08, d); check(d == 16'h020, "R2 unlocked reload", d, 'h20);

      // R6 / R5 busy flags
      do_reset();
      tick_en = 1'b0;
      wr(5'h00, 16'h5555); wr(5'h04, 16'h2);
      rd(5'h0C, d); check(d == 16'h1, "R6 pre busy set", d, 1);
      repeat (10) @(negedge clk);
      rd(5'h0C, d); check(d == 16'h1, "R5 busy held without ticks", d, 1);
      tick_en = 1'b1;
      repeat (3) @(negedge clk);
      rd(5'h0C, d); check(d == 16'h1, "R6 busy after 3 ticks", d, 1);
      @(negedge clk);
      rd(5'h0C, d); check(d == 16'h0, "R6 busy clear after 4 ticks", d, 0);
      wr(5'h08, 16'h7);
      rd(5'h0C, d); check(d == 16'h2, "R6 reload busy bit", d, 2);

      // R4 directed period and repeat
      do_reset();
      setup(3, 0);
      wr(5'h00, 16'hCCCC);
      measure(1'b0, 5000, n); check(n == 16, "R4 first period", n, 16);
      measure(1'b0, 5000, n); check(n == 16, "R4 second period", n, 16);
      @(negedge clk);
      check(rst_req == 1'b0, "R4 one-cycle pulse", rst_req, 0);

      // R3 saturating code 7
      do_reset();
      setup(1, 7);
      wr(5'h00, 16'hCCCC);
      measure(1'b0, 5000, n); check(n == 512, "R3 code 7", n, 512);

      // R7 refresh before start ignored, then refresh while running
      do_reset();
      setup(2, 0);
      wr(5'h00, 16'hAAAA);
      seen = 0;
      repeat (40) begin @(negedge clk); if (rst_req) seen++; end
      check(seen == 0, "R7 refresh before start", seen, 0);
      wr(5'h00, 16'hCCCC);
      repeat (8) @(negedge clk);
      wr(5'h00, 16'hAAAA);
      measure(1'b0, 5000, n); check(n == 12, "R7 refresh restarts period", n, 12);

      // R6 old reload governs until carried over
      tick_en = 1'b0;
      wr(5'h00, 16'h5555); wr(5'h08, 16'h5); wr(5'h00, 16'hAAAA);
      measure(1'b0, 5000, n); check(n == 12, "R6 old reload in force", n, 12);
      measure(1'b0, 5000, n); check(n == 24, "R6 new reload applied", n, 24);

      // R8 window boundary
      do_reset();
      wr(5'h00, 16'h5555); wr(5'h10, 16'h020);
      setup(16'h40, 0);
      tick_en = 1'b0;
      wr(5'h00, 16'hCCCC);
      wr(5'h00, 16'hAAAA);
      check(rst_req == 1'b1, "R8 early refresh", rst_req, 1);
      wr(5'h00, 16'h5555); wr(5'h10, 16'h040); wr(5'h00, 16'hAAAA);
      check(rst_req == 1'b0, "R8 refresh at window", rst_req, 0);
      wr(5'h00, 16'h5555); wr(5'h10, 16'h03F); wr(5'h00, 16'hAAAA);
      check(rst_req == 1'b1, "R8 refresh one above window", rst_req, 1);

      // R9 lock key does not stop
      wr(5'h00, 16'h0000);
      measure(1'b0, 2000, n);
      check(rst_req == 1'b1 && n <= 270, "R9 still running", n, 260);

      // R4 / R5 random configurations with gapped ticks
      for (int i = 0; i < 8; i++) begin
         int rl, cd;
         rl = int'($urandom % 24);
         cd = int'($urandom % 4);
         do_reset();
         setup(rl, cd);
         wr(5'h00, 16'hCCCC);
         measure(1'b1, 5000, n);
         check(n == exp_period(rl, cd), "R5 random period", n, exp_period(rl, cd));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule